// File: doc/BRIEF.md
# Flow-Control Next-PC Generator

This block sits in the fetch/branch stage of a small RISC core that mixes 16-bit and 32-bit instructions. It decodes the program-flow instructions and works out the address of the next instruction, whether the flow changes, and whether the link register is written and with what value. The condition code is evaluated elsewhere and arrives as a single condition-true bit. The operand register needed by the register-indirect and memory-indirect calls is read through the register file. Its index is given combinationally on `reg_idx_o`, and its value comes back on `reg_val_i` in the same cycle.

The first halfword of every instruction is always presented on `instr_i[31:16]`. For a 32-bit instruction, the second halfword is on `instr_i[15:0]`. All displacements are added to the address of the current instruction. For the memory-indirect call the block does not read memory. It places the table address, from which the real target must be fetched, on `npc_o` and raises `tbl_o`. All results are registered, so they appear one clock after the inputs.

Top module: `flow_npc`

## Requirements
- R1: A 16-bit application call (first halfword 1101 xxxx xxxx 0000) sets next PC to call_base_i + (bits [11:4] of the halfword, zero-extended, times 4), writes link with PC+2 and raises taken.
- R2: A 16-bit short branch (first halfword 1100 xxxx xxxx 0ccc) with cond_i=1 sets next PC to PC + sign-extended bits [11:4] times 2 and raises taken without a link write. With cond_i=0 the next PC is PC+2 and taken is low.
- R3: A 32-bit long branch (first halfword bits [15:13]=111 and [8:5]=0100) uses a 21-bit displacement built from halfword bits [12:9] as bits 20:17, halfword bit [4] as bit 16 and the second halfword as bits 15:0. If cond_i=1 the next PC is PC + sign-extended displacement times 2. Otherwise it is PC+4. There is no link write.
- R4: A 16-bit relative jump (first halfword 1100 xxxx xxxx 10yy) always branches to PC + 2 * a sign-extended 10-bit displacement, with yy as its top two bits and bits [11:4] as its low eight bits, regardless of cond_i.
- R5: A 16-bit short relative call (1100 xxxx xxxx 11yy) uses the same 10-bit displacement as R4, branches unconditionally and writes link with PC+2.
- R6: A 32-bit long relative call (first halfword bits [15:13]=111, [8:5]=0101, [3:0]=0000) uses the 21-bit displacement of R3, branches unconditionally and writes link with PC+4.
- R7: A 16-bit register-indirect call (0101 1101 0001 dddd) drives reg_idx_o with dddd, sets next PC to reg_val_i with bit 0 cleared and writes link with PC+2.
- R8: A 32-bit memory-indirect call (first halfword 1111 0000 0001 pppp) raises tbl_o and taken. It puts (reg_val_i with bits 1:0 cleared) + sign-extended second halfword times 4 on npc_o and writes link with PC+4.
- R9: An instruction that is not a flow instruction, or whose encoding does not match long_i, gives next PC = PC+2 (long_i=0) or PC+4 (long_i=1), with taken, link write and tbl_o all low.
- R10: Bit 0 of npc_o is always zero.
- R11: While rst_ni is low, npc_o, link_o, taken_o, link_we_o and tbl_o are all zero. Otherwise every output except reg_idx_o reflects the inputs of the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction, first halfword in [31:16] |
| long_i | input | 1 | 1 = 32-bit instruction |
| pc_i | input | 32 | Address of the current instruction |
| reg_val_i | input | 32 | Value of register reg_idx_o |
| call_base_i | input | 32 | Application-call base register |
| cond_i | input | 1 | Branch condition is true |
| reg_idx_o | output | 4 | Register-file read index (combinational) |
| npc_o | output | 32 | Next PC, or table address when tbl_o is high |
| taken_o | output | 1 | Flow change |
| link_we_o | output | 1 | Write link register |
| link_o | output | 32 | Value for the link register |
| tbl_o | output | 1 | npc_o holds a call-table address |

## Verification
A wrong decode or a wrong displacement field shows up on npc_o one clock after the instruction is applied. It is an exact value error, so the vectors place set bits in each split displacement field on its own and also drive both sign extremes. A wrong form decision shows up in the same cycle on taken_o, link_we_o or tbl_o. A wrong length decision shows up in the same cycle as a fall-through of 2 where 4 was due. Nothing is held between instructions beyond the output register, so no error can stay hidden for more than one cycle.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [1:0] {B_PC, B_CBASE, B_REG, B_REGW} base_e;
  typedef enum logic [2:0] {O_LEN, O_D8, O_D10, O_D21, O_U8X4, O_D16X4, O_ZERO} off_e;

  typedef struct packed {
    logic  taken;
    logic  link;
    logic  tbl;
    base_e base;
    off_e  off;
  } dec_t;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [15:0] hw_i,
  input  logic        long_i,
  input  logic        cond_i,
  output dec_t        dec_o
);
  logic is_acall, is_brs, is_rjmp, is_rcs, is_icall, is_brl, is_rcl, is_mcall;

  always_comb begin
    is_acall = !long_i && hw_i[15:12] == 4'hd && hw_i[3:0] == 4'h0;
    is_brs   = !long_i && hw_i[15:12] == 4'hc && !hw_i[3];
    is_rjmp  = !long_i && hw_i[15:12] == 4'hc && hw_i[3:2] == 2'b10;
    is_rcs   = !long_i && hw_i[15:12] == 4'hc && hw_i[3:2] == 2'b11;
    is_icall = !long_i && hw_i[15:4] == 12'h5d1;
    is_brl   =  long_i && hw_i[15:13] == 3'b111 && hw_i[8:5] == 4'b0100;
    is_rcl   =  long_i && hw_i[15:13] == 3'b111 && hw_i[8:5] == 4'b0101 && hw_i[3:0] == 4'h0;
    is_mcall =  long_i && hw_i[15:4] == 12'hf01;
  end

  always_comb begin
    dec_o = '{taken: 1'b0, link: 1'b0, tbl: 1'b0, base: B_PC, off: O_LEN};
    if (is_acall)
      dec_o = '{taken: 1'b1, link: 1'b1, tbl: 1'b0, base: B_CBASE, off: O_U8X4};
    else if (is_brs && cond_i)
      dec_o = '{taken: 1'b1, link: 1'b0, tbl: 1'b0, base: B_PC, off: O_D8};
    else if (is_rjmp)
      dec_o = '{taken: 1'b1, link: 1'b0, tbl: 1'b0, base: B_PC, off: O_D10};
    else if (is_rcs)
      dec_o = '{taken: 1'b1, link: 1'b1, tbl: 1'b0, base: B_PC, off: O_D10};
    else if (is_icall)
      dec_o = '{taken: 1'b1, link: 1'b1, tbl: 1'b0, base: B_REG, off: O_ZERO};
    else if (is_brl && cond_i)
      dec_o = '{taken: 1'b1, link: 1'b0, tbl: 1'b0, base: B_PC, off: O_D21};
    else if (is_rcl)
      dec_o = '{taken: 1'b1, link: 1'b1, tbl: 1'b0, base: B_PC, off: O_D21};
    else if (is_mcall)
      dec_o = '{taken: 1'b1, link: 1'b1, tbl: 1'b1, base: B_REGW, off: O_D16X4};
  end
endmodule

// File: rtl/flow_target.sv
module flow_target
  import flow_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   instr_i,
  input  logic          long_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [AW-1:0] call_base_i,
  input  dec_t          dec_i,
  output logic [AW-1:0] tgt_o
);
  localparam int DW21 = 21;
  logic [15:0]   hw, lo;
  logic [AW-1:0] base, off, sum;

  assign hw = instr_i[31:16];
  assign lo = instr_i[15:0];

  always_comb begin
    unique case (dec_i.base)
      B_CBASE: base = call_base_i;
      B_REG:   base = reg_val_i;
      B_REGW:  base = {reg_val_i[AW-1:2], 2'b00};
      default: base = pc_i;
    endcase
  end

  always_comb begin
    unique case (dec_i.off)
      O_D8:    off = {{(AW-9){hw[11]}}, hw[11:4], 1'b0};
      O_D10:   off = {{(AW-11){hw[1]}}, hw[1:0], hw[11:4], 1'b0};
      O_D21:   off = {{(AW-DW21-1){hw[12]}}, hw[12:9], hw[4], lo, 1'b0};
      O_U8X4:  off = {{(AW-10){1'b0}}, hw[11:4], 2'b00};
      O_D16X4: off = {{(AW-18){lo[15]}}, lo, 2'b00};
      O_ZERO:  off = '0;
      default: off = long_i ? AW'(4) : AW'(2);
    endcase
  end

  assign sum   = base + off;
  assign tgt_o = {sum[AW-1:1], 1'b0};
endmodule

// File: rtl/flow_npc.sv
module flow_npc
  import flow_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   instr_i,
  input  logic          long_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [AW-1:0] call_base_i,
  input  logic          cond_i,
  output logic [3:0]    reg_idx_o,
  output logic [AW-1:0] npc_o,
  output logic          taken_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_o,
  output logic          tbl_o
);
  dec_t          dec;
  logic [AW-1:0] tgt, nxt;

  assign reg_idx_o = instr_i[19:16];
  assign nxt       = pc_i + (long_i ? AW'(4) : AW'(2));

  flow_decode u_dec (
    .hw_i  (instr_i[31:16]),
    .long_i(long_i),
    .cond_i(cond_i),
    .dec_o (dec)
  );

  flow_target #(.AW(AW)) u_tgt (
    .instr_i    (instr_i),
    .long_i     (long_i),
    .pc_i       (pc_i),
    .reg_val_i  (reg_val_i),
    .call_base_i(call_base_i),
    .dec_i      (dec),
    .tgt_o      (tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_o     <= '0;
      taken_o   <= 1'b0;
      link_we_o <= 1'b0;
      link_o    <= '0;
      tbl_o     <= 1'b0;
    end else begin
      npc_o     <= tgt;
      taken_o   <= dec.taken;
      link_we_o <= dec.link;
      link_o    <= nxt;
      tbl_o     <= dec.tbl;
    end
  end

  AST_NPC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc_o[0] == 1'b0); // R10
  AST_TBL_IS_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_o |-> (link_we_o && taken_o)); // R8
  AST_LINK_NEEDS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> taken_o); // R9
  AST_FALLTHROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !taken_o) |-> npc_o == $past(pc_i) + ($past(long_i) ? AW'(4) : AW'(2))); // R9
  AST_LINK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && link_we_o) |-> link_o == $past(pc_i) + ($past(long_i) ? AW'(4) : AW'(2))); // R1
endmodule

// File: tb/flow_npc_test.sv
`timescale 1ns/1ps
module flow_npc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, pc = '0, rv = '0, cb = '0;
  logic        lng = 1'b0, cond = 1'b0;
  logic [3:0]  ridx;
  logic [31:0] npc, link;
  logic        taken, lwe, tbl;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] npc;
    logic        taken;
    logic        lwe;
    logic [31:0] link;
    logic        tbl;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  flow_npc uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .long_i(lng), .pc_i(pc),
    .reg_val_i(rv), .call_base_i(cb), .cond_i(cond), .reg_idx_o(ridx),
    .npc_o(npc), .taken_o(taken), .link_we_o(lwe), .link_o(link), .tbl_o(tbl)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] i, input logic l, input logic [31:0] p,
                       input logic [31:0] r, input logic [31:0] b, input logic c,
                       input logic [31:0] e_npc, input logic e_tk, input logic e_we,
                       input logic [31:0] e_link, input logic e_tbl);
    exp_t e;
    @(negedge clk);
    instr = i; lng = l; pc = p; rv = r; cb = b; cond = c;
    e.npc = e_npc; e.taken = e_tk; e.lwe = e_we; e.link = e_link; e.tbl = e_tbl; e.req = req;
    sb.push_back(e);
    @(posedge clk);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "npc", npc, e.npc);
      chk(e.req, "taken", {31'b0, taken}, {31'b0, e.taken});
      chk(e.req, "link_we", {31'b0, lwe}, {31'b0, e.lwe});
      if (e.lwe) chk(e.req, "link", link, e.link);
      chk(e.req, "tbl", {31'b0, tbl}, {31'b0, e.tbl});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "npc", npc, 32'h0);
    chk("R11", "flags", {29'b0, taken, lwe, tbl}, 32'h0);
    chk("R11", "link", link, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 application call, then top of offset range
    apply("R1", {16'hd120, 16'ha5a5}, 0, 32'h1000, 0, 32'h8000_0000, 0, 32'h8000_0048, 1, 1, 32'h1002, 0);
    apply("R1", {16'hdff0, 16'h0000}, 0, 32'h2000, 0, 32'h0000_0100, 0, 32'h0000_04fc, 1, 1, 32'h2002, 0);
    // R10 odd call base still gives an even target
    apply("R10", {16'hd000, 16'h0000}, 0, 32'h3000, 0, 32'h0000_0101, 0, 32'h0000_0100, 1, 1, 32'h3002, 0);
    // R2 short branch: forward, most negative, not taken
    apply("R2", {16'hc103, 16'h1234}, 0, 32'h1000, 0, 0, 1, 32'h1020, 1, 0, 0, 0);
    apply("R2", {16'hc800, 16'h0000}, 0, 32'h1000, 0, 0, 1, 32'h0f00, 1, 0, 0, 0);
    apply("R2", {16'hc103, 16'h0000}, 0, 32'h1000, 0, 0, 0, 32'h1002, 0, 0, 0, 0);
    // R4 relative jump ignores cond: most negative, most positive
    apply("R4", {16'hc00a, 16'h0000}, 0, 32'h1000, 0, 0, 0, 32'h0c00, 1, 0, 0, 0);
    apply("R4", {16'hcff9, 16'h0000}, 0, 32'h1000, 0, 0, 0, 32'h13fe, 1, 0, 0, 0);
    // R5 short relative call
    apply("R5", {16'hc04c, 16'h0000}, 0, 32'h1000, 0, 0, 0, 32'h1008, 1, 1, 32'h1002, 0);
    // R3 long branch: most negative, split fields, not taken
    apply("R3", {16'hf080, 16'h0000}, 1, 32'h0040_0000, 0, 0, 1, 32'h0020_0000, 1, 0, 0, 0);
    apply("R3", {16'he290, 16'h1234}, 1, 32'h1000, 0, 0, 1, 32'h0006_3468, 1, 0, 0, 0);
    apply("R3", {16'he290, 16'h1234}, 1, 32'h1000, 0, 0, 0, 32'h1004, 0, 0, 0, 0);
    // R6 long relative call
    apply("R6", {16'he0a0, 16'h0010}, 1, 32'h2000, 0, 0, 0, 32'h2020, 1, 1, 32'h2004, 0);
    // R7 register-indirect call, index driven combinationally
    @(negedge clk);
    instr = {16'h5d17, 16'h0000}; lng = 0;
    #0.5 chk("R7", "reg_idx", {28'b0, ridx}, 32'h7);
    apply("R7", {16'h5d17, 16'h0000}, 0, 32'h1000, 32'h0000_3457, 0, 0, 32'h3456, 1, 1, 32'h1002, 0);
    // R8 memory-indirect call table address
    @(negedge clk);
    instr = {16'hf013, 16'hffff}; lng = 1;
    #0.5 chk("R8", "reg_idx", {28'b0, ridx}, 32'h3);
    apply("R8", {16'hf013, 16'hffff}, 1, 32'h1000, 32'h0000_2003, 0, 0, 32'h0000_1ffc, 1, 1, 32'h1004, 1);
    // R9 non-flow and length mismatch
    apply("R9", {16'h0000, 16'h0000}, 0, 32'h4000, 0, 0, 1, 32'h4002, 0, 0, 0, 0);
    apply("R9", {16'h0000, 16'h0000}, 1, 32'h4000, 0, 0, 1, 32'h4004, 0, 0, 0, 0);
    apply("R9", {16'hd120, 16'h0000}, 1, 32'h4000, 0, 32'h8000, 1, 32'h4004, 0, 0, 0, 0);
    apply("R9", {16'hf013, 16'h0000}, 0, 32'h4000, 32'h100, 0, 1, 32'h4002, 0, 0, 0, 0);

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule